// File: doc/BRIEF.md
# Write-Protection Command Sequence Detector

This block sits beside the byte-load path of a parallel non-volatile memory and watches every completed byte-write cycle, each one an address and a data byte. It recognises two fixed key sequences. A three-write arm sequence switches protection on and opens a window for exactly one page load. A six-write kill sequence, which starts with the same two writes, switches protection off. While protection is on and no window is open, ordinary writes are thrown away. The first two writes of both sequences are the same, so one tracker follows both of them.

The protection flag stands for a bit held in non-volatile storage. Here it is a register whose power-up value comes from a parameter. The page-load controller takes three things from this block: a one-cycle grant for each write it may store, a level that shows the one-shot load window is open, and a pulse that starts the programming timer when the flag is rewritten. The controller closes the window with a pulse once the page load has ended. Protection then stays on, so the next data write needs the arm sequence again.

Top module: `wp_cmd_guard`

## Requirements
- R1: After reset, `prot_en` equals the PROT_INIT parameter (default 0), and `wr_grant`, `prog_start` and `load_window` are 0.
- R2: When protection is off, a write that does not take part in a key sequence raises `wr_grant` for exactly the cycle after the write.
- R3: When protection is on and no window is open, a write that is not part of a key sequence gives no `wr_grant` and leaves `prot_en` unchanged.
- R4: The arm sequence is data AAh to address 5555h, then 55h to 2AAAh, then A0h to 5555h. None of these writes is granted. In the cycle after the third write, `prot_en` and `load_window` are 1 and `prog_start` pulses for one cycle. This holds whether protection was on or off before.
- R5: While `load_window` is 1, every write is granted and no key decoding takes place. A `page_closed` pulse closes the window after its own cycle (a write in that same cycle is still granted), and `prot_en` stays 1.
- R6: The kill sequence is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h. None of these writes is granted. In the cycle after the sixth write, `prot_en` is 0 and `prog_start` pulses for one cycle.
- R7: Addresses are compared on all 15 bits. A write that does not match the next expected pair ends the partial sequence and is then handled as an ordinary write under R2 or R3. A write that matches a sequence step is never granted, even when protection is off.
- R8: A write of AAh to 5555h that does not fit the current step starts a new sequence at step one. Only the fourth step of the kill sequence expects this write.
- R9: A `page_closed` pulse while no window is open changes neither `prot_en` nor `load_window`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | A completed byte write is presented this cycle |
| wr_addr | input | 15 | Address of the write |
| wr_data | input | 8 | Data of the write |
| page_closed | input | 1 | Pulse from the page-load controller: the load has ended |
| wr_grant | output | 1 | Pulse: the write of the previous cycle may be stored |
| prog_start | output | 1 | Pulse: start the programming timer for a flag change |
| prot_en | output | 1 | Protection flag |
| load_window | output | 1 | One-shot page-load window is open |

## Verification
A tracker that is one step off shows up within one cycle of the next write. A command write comes out granted when it should be dropped, or a finished sequence gives no `prog_start` and no change of `prot_en`. A window that opens or closes at the wrong time shows as a grant that is present or missing on the first write after that event. The bench follows the sequence position with its own counter that indexes the six-write list, and it compares all four outputs in every cycle. A drifted state therefore appears in the cycle after the write that exposes it.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Classified meaning of one presented write
  typedef enum logic [2:0] {
    TK_NONE,
    TK_OTHER,
    TK_KEY1,   // first key byte at primary address
    TK_KEY2,   // second key byte at secondary address
    TK_ARM,    // arm closer at primary address
    TK_PRE,    // kill prefix at primary address
    TK_KILL    // kill closer at primary address
  } tok_t;

  // Position inside the shared arm/kill key sequence
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_K1,
    SQ_K2,
    SQ_PRE,
    SQ_PK1,
    SQ_PK2
  } seq_t;

  function automatic logic pair_eq(input logic [31:0] a, input logic [31:0] ea,
                                   input logic [15:0] d, input logic [15:0] ed);
    return (a == ea) && (d == ed);
  endfunction

endpackage

// File: rtl/wp_key_decode.sv
module wp_key_decode
  import wp_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter logic [AW-1:0] ADDR_P = 'h5555,
  parameter logic [AW-1:0] ADDR_Q = 'h2AAA,
  parameter logic [DW-1:0] KEY_FIRST  = 'hAA,
  parameter logic [DW-1:0] KEY_SECOND = 'h55,
  parameter logic [DW-1:0] KEY_ARM    = 'hA0,
  parameter logic [DW-1:0] KEY_PRE    = 'h80,
  parameter logic [DW-1:0] KEY_KILL   = 'h20
) (
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output tok_t          tok
);
  localparam logic [31:0] AP = 32'(ADDR_P);
  localparam logic [31:0] AQ = 32'(ADDR_Q);

  logic [31:0] a32;
  logic [15:0] d16;
  assign a32 = 32'(addr);
  assign d16 = 16'(data);

  always_comb begin
    tok = TK_OTHER;
    if (!valid)                                    tok = TK_NONE;
    else if (pair_eq(a32, AP, d16, 16'(KEY_FIRST)))  tok = TK_KEY1;
    else if (pair_eq(a32, AQ, d16, 16'(KEY_SECOND))) tok = TK_KEY2;
    else if (pair_eq(a32, AP, d16, 16'(KEY_ARM)))    tok = TK_ARM;
    else if (pair_eq(a32, AP, d16, 16'(KEY_PRE)))    tok = TK_PRE;
    else if (pair_eq(a32, AP, d16, 16'(KEY_KILL)))   tok = TK_KILL;
  end

endmodule

// File: rtl/wp_seq_track.sv
module wp_seq_track
  import wp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic in_window,
  input  tok_t tok,
  output logic is_cmd,
  output logic ev_arm,
  output logic ev_kill
);
  seq_t st, nxt;

  always_comb begin
    nxt     = st;
    is_cmd  = 1'b0;
    ev_arm  = 1'b0;
    ev_kill = 1'b0;
    if (wr_valid && !in_window) begin
      // default: abort, or restart on the opening key
      if (tok == TK_KEY1) begin
        nxt    = SQ_K1;
        is_cmd = 1'b1;
      end else begin
        nxt    = SQ_IDLE;
      end
      unique case (st)
        SQ_K1:  if (tok == TK_KEY2) begin nxt = SQ_K2; is_cmd = 1'b1; end
        SQ_K2: begin
          if (tok == TK_ARM) begin
            nxt = SQ_IDLE; is_cmd = 1'b1; ev_arm = 1'b1;
          end else if (tok == TK_PRE) begin
            nxt = SQ_PRE; is_cmd = 1'b1;
          end
        end
        SQ_PRE: if (tok == TK_KEY1) begin nxt = SQ_PK1; is_cmd = 1'b1; end
        SQ_PK1: if (tok == TK_KEY2) begin nxt = SQ_PK2; is_cmd = 1'b1; end
        SQ_PK2: if (tok == TK_KILL) begin
          nxt = SQ_IDLE; is_cmd = 1'b1; ev_kill = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= nxt;
  end

  // R7: a write that is no key at all drops any partial progress
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !in_window && tok == TK_OTHER) |=> (st == SQ_IDLE));

  // R8: the opening key always leaves the tracker at a step past idle
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !in_window && tok == TK_KEY1) |=> (st == SQ_K1 || st == SQ_PK1));

endmodule

// File: rtl/wp_prot_reg.sv
module wp_prot_reg #(
  parameter logic PROT_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic is_cmd,
  input  logic ev_arm,
  input  logic ev_kill,
  input  logic page_closed,
  output logic wr_grant,
  output logic prog_start,
  output logic prot_q,
  output logic win_q
);
  logic data_ok;

  assign data_ok = wr_valid && (win_q || (!is_cmd && !prot_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q     <= PROT_INIT;
      win_q      <= 1'b0;
      wr_grant   <= 1'b0;
      prog_start <= 1'b0;
    end else begin
      wr_grant   <= data_ok;
      prog_start <= ev_arm | ev_kill;
      if (ev_arm)       prot_q <= 1'b1;
      else if (ev_kill) prot_q <= 1'b0;
      if (ev_arm)           win_q <= 1'b1;
      else if (page_closed) win_q <= 1'b0;
    end
  end

  // R3: protected, no window, ordinary write: never granted
  p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && prot_q && !win_q) |=> !wr_grant);

  // R4: arm completion sets flag, opens window, starts timer
  p_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arm |=> (prot_q && win_q && prog_start));

  // R6: kill completion clears flag and starts timer
  p_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_kill |=> (!prot_q && !win_q && prog_start));

  // R7: command writes are never stored
  p_cmd_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && is_cmd) |=> !wr_grant);

  // R5: the window only exists under protection, and closes on request
  p_win_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_q |-> prot_q);
  p_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && page_closed) |=> (!win_q && prot_q));

  // R9: stray close pulse has no effect
  p_noclose_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_q && page_closed && !ev_arm && !ev_kill) |=> ($stable(prot_q) && !win_q));

endmodule

// File: rtl/wp_cmd_guard.sv
module wp_cmd_guard
  import wp_pkg::*;
#(
  parameter int   AW        = 15,
  parameter int   DW        = 8,
  parameter logic PROT_INIT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          page_closed,
  output logic          wr_grant,
  output logic          prog_start,
  output logic          prot_en,
  output logic          load_window
);
  tok_t tok;
  logic is_cmd, ev_arm, ev_kill;
  logic prot_q, win_q;

  wp_key_decode #(.AW(AW), .DW(DW)) u_dec (
    .valid (wr_valid),
    .addr  (wr_addr),
    .data  (wr_data),
    .tok   (tok)
  );

  wp_seq_track u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .in_window (win_q),
    .tok       (tok),
    .is_cmd    (is_cmd),
    .ev_arm    (ev_arm),
    .ev_kill   (ev_kill)
  );

  wp_prot_reg #(.PROT_INIT(PROT_INIT)) u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .is_cmd      (is_cmd),
    .ev_arm      (ev_arm),
    .ev_kill     (ev_kill),
    .page_closed (page_closed),
    .wr_grant    (wr_grant),
    .prog_start  (prog_start),
    .prot_q      (prot_q),
    .win_q       (win_q)
  );

  assign prot_en     = prot_q;
  assign load_window = win_q;

  // R4/R6: the two completion events never coincide
  p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_arm && ev_kill));

endmodule

// File: tb/sim_wp_cmd_guard.sv
module sim_wp_cmd_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        page_closed = 1'b0;
  logic        wr_grant, prog_start, prot_en, load_window;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  // bench model state
  int m_pos = 0;
  bit m_prot = 0;
  bit m_win = 0;

  always #2 clk = ~clk;

  wp_cmd_guard u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .page_closed(page_closed), .wr_grant(wr_grant),
    .prog_start(prog_start), .prot_en(prot_en), .load_window(load_window)
  );

  // the six-write kill list, indexed by progress
  function automatic logic [22:0] kill_step(input int i);
    case (i)
      0: return {15'h5555, 8'hAA};
      1: return {15'h2AAA, 8'h55};
      2: return {15'h5555, 8'h80};
      3: return {15'h5555, 8'hAA};
      4: return {15'h2AAA, 8'h55};
      default: return {15'h5555, 8'h20};
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic cyc(input bit v, input logic [14:0] a, input logic [7:0] d, input bit pc);
    bit eg, ep;
    string tag;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; page_closed = pc;
    @(posedge clk);
    #1;
    eg = 0; ep = 0; tag = "R2";
    if (v) begin
      if (m_win) begin
        eg = 1; tag = "R5";
      end else if (m_pos == 2 && a == 15'h5555 && d == 8'hA0) begin
        m_pos = 0; m_prot = 1; ep = 1; tag = "R4";
      end else if ({a, d} == kill_step(m_pos)) begin
        m_pos++; tag = "R7";
        if (m_pos == 6) begin m_pos = 0; m_prot = 0; ep = 1; tag = "R6"; end
      end else if (a == 15'h5555 && d == 8'hAA) begin
        m_pos = 1; tag = "R8";
      end else begin
        m_pos = 0; eg = !m_prot; tag = m_prot ? "R3" : "R2";
      end
    end
    if (ep && tag == "R4") m_win = 1;
    else if (pc) begin
      if (!m_win) tag = "R9";
      m_win = 0;
    end
    chk(tag, wr_grant, eg, "grant");
    chk(tag, prog_start, ep, "prog_start");
    chk(tag, prot_en, m_prot, "prot_en");
    chk(tag, load_window, m_win, "load_window");
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    cyc(1, a, d, 0);
  endtask

  task automatic arm_seq();
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
  endtask

  task automatic kill_seq();
    for (int i = 0; i < 6; i++) wr(kill_step(i)[22:8], kill_step(i)[7:0]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual cycles=%0d expected completion", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", prot_en, 1'b0, "prot_en");
    chk("R1", wr_grant, 1'b0, "grant");
    chk("R1", prog_start, 1'b0, "prog_start");
    chk("R1", load_window, 1'b0, "load_window");
    @(negedge clk); rst_n = 1'b1;

    // R2 unprotected plain writes
    wr(15'h0123, 8'h3C); wr(15'h7FFF, 8'h00);
    // R9 stray close, R7 near-miss address (one bit off)
    cyc(0, '0, '0, 1);
    wr(15'h5555, 8'hAA); wr(15'h2AAB, 8'h55); wr(15'h1000, 8'h11);
    // R4 arm from unprotected, then R5 window
    arm_seq();
    wr(15'h0200, 8'h01); wr(15'h5555, 8'hAA); wr(15'h0202, 8'h03);
    cyc(1, 15'h0203, 8'h04, 1);
    // R3 protected drop
    wr(15'h0204, 8'h05);
    cyc(0, '0, '0, 1);
    // R8 restart mid-sequence, then arm again while protected
    wr(15'h5555, 8'hAA); wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
    cyc(0, '0, '0, 1);
    // R7 abort in protected mode at the kill tail
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h21);
    // R6 kill, then plain write granted
    kill_seq();
    wr(15'h4444, 8'h77);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [14:0] a;
      logic [7:0] d;
      r = $urandom % 16;
      a = 15'($urandom); d = 8'($urandom);
      case (r)
        0, 1: begin a = 15'h5555; d = 8'hAA; end
        2, 3: begin a = 15'h2AAA; d = 8'h55; end
        4:    begin a = 15'h5555; d = 8'hA0; end
        5:    begin a = 15'h5555; d = 8'h80; end
        6:    begin a = 15'h5555; d = 8'h20; end
        7:    begin a = 15'h5555 ^ (15'h1 << ($urandom % 15)); d = 8'hAA; end
        8:    arm_seq();
        9:    if ($urandom % 4 == 0) kill_seq();
        default: ;
      endcase
      cyc(($urandom % 8) != 0, a, d, ($urandom % 8) == 0);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule